// File: doc/BRIEF.md
# Ethernet Receive Filter Chain

This block gives a keep-or-drop verdict for every Ethernet frame the receive path finishes. It runs eleven filters in a fixed priority order, and software enables each one on its own. A collection filter can only keep a frame or pass the decision down to the next filter. A rejection filter can only drop a frame or pass the decision down. The highest-priority enabled filter that matches the frame decides. A frame that no filter keeps is dropped.

The receive datapath supplies four things:
- a start-of-frame strobe;
- the destination address bytes as they arrive;
- an end-of-frame strobe that carries the CRC status and the byte length;
- three match flags from separate hash-table, wake-up-frame and pattern engines.

The enable set is held in a local register that software writes. At each start of frame the block copies that register, so a write made while a frame is arriving cannot change that frame's verdict. The verdict is a one-cycle pulse in the clock after the end-of-frame strobe.

Top module: `eth_rx_filter_chain`

## Requirements
- R1: The enable word has one bit per filter, and bit i enables filter i. The list below goes from highest to lowest priority:
  - bit 0: CRC-error collect
  - bit 1: runt collect
  - bit 2: CRC-error reject
  - bit 3: runt reject
  - bit 4: own-address unicast collect
  - bit 5: other-address unicast collect
  - bit 6: multicast collect
  - bit 7: broadcast collect
  - bit 8: hash collect
  - bit 9: wake-up collect
  - bit 10: pattern collect
- R2: The lowest-numbered enabled filter whose condition holds decides the verdict. Collect filters keep the frame and reject filters drop it. If no enabled filter matches, the frame is dropped.
- R3: The destination is taken with its first byte as the most significant byte. Its class is fixed as follows:
  - broadcast when all 48 bits are 1;
  - multicast when bit 0 of the first byte is 1 and the address is not broadcast;
  - unicast when that bit is 0.
  Own-address unicast means the destination equals `local_mac`. Other-address unicast means it differs from `local_mac`.
- R4: A frame is a runt when `eof_len` is below 64. It has a CRC error when `eof_crc_ok` is 0. Both filters of each pair use the same condition.
- R5: After reset the enable register holds 0x09C, which enables bits 2, 3, 4 and 7. With this setting, only broadcast frames and error-free own-address frames are kept.
- R6: The enable set that applies to a frame is the register value at the start-of-frame cycle. A write in that cycle or later affects only the next frame.
- R7: An `eof` that closes an open frame produces `verdict_valid` high for exactly one cycle, in the cycle that follows, with `verdict_keep` alongside it.
- R8: When `sof` and `eof` arrive in the same cycle, no verdict is given for the frame that was open, and a new frame starts. An `eof` with no open frame produces no verdict.
- R9: The first six bytes with `byte_vld` high, counted from the `sof` cycle, form the destination address. Later bytes are ignored. Bytes that never arrive read as zero.
- R10: `hash_hit`, `magic_hit` and `pattern_hit` are sampled in the `eof` cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe |
| byte_vld | input | 1 | Qualifies `byte_in` |
| byte_in | input | 8 | Received frame byte |
| eof | input | 1 | End-of-frame strobe |
| eof_crc_ok | input | 1 | CRC was good; valid with `eof` |
| eof_len | input | 16 | Frame length in bytes; valid with `eof` |
| local_mac | input | 48 | Station address, first byte in bits 47:40 |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 11 | Enable register write value |
| hash_hit | input | 1 | Hash-table match for the ending frame |
| magic_hit | input | 1 | Wake-up-frame match for the ending frame |
| pattern_hit | input | 1 | Pattern match for the ending frame |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_keep | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
The assertions assume that `sof` and `eof` are single-cycle strobes, and that a frame's address bytes arrive strictly between its `sof` and its `eof` (or in the `sof` cycle itself). They also assume that the status and match inputs mean something only in the `eof` cycle. The stimulus follows these rules: every frame is a `sof` with its first byte, then the remaining bytes, then a separate `eof` cycle. Only two directed cases step outside them: the same-cycle `sof`/`eof` cancel, and the orphan `eof`. Both exist to exercise R8.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int NUM_FILT  = 11;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = MAC_BYTES * 8;

    typedef enum logic [3:0] {
        F_CRC_COLL   = 4'd0,
        F_RUNT_COLL  = 4'd1,
        F_CRC_REJ    = 4'd2,
        F_RUNT_REJ   = 4'd3,
        F_UC_ME      = 4'd4,
        F_UC_OTHER   = 4'd5,
        F_MCAST      = 4'd6,
        F_BCAST      = 4'd7,
        F_HASH       = 4'd8,
        F_MAGIC      = 4'd9,
        F_PATTERN    = 4'd10
    } filt_id_e;

    // 1 = collection (keeps on hit), 0 = rejection (drops on hit)
    localparam logic [NUM_FILT-1:0] COLLECT_MASK =
        ~((NUM_FILT'(1) << F_CRC_REJ) | (NUM_FILT'(1) << F_RUNT_REJ));

    localparam logic [NUM_FILT-1:0] EN_DEFAULT =
        (NUM_FILT'(1) << F_CRC_REJ) | (NUM_FILT'(1) << F_RUNT_REJ) |
        (NUM_FILT'(1) << F_UC_ME)   | (NUM_FILT'(1) << F_BCAST);

    typedef struct packed {
        logic bcast;
        logic mcast;
        logic uc_me;
        logic uc_other;
    } addr_class_t;

    typedef struct packed {
        logic crc_bad;
        logic runt;
        logic hash_hit;
        logic magic_hit;
        logic pattern_hit;
    } frame_stat_t;

    function automatic addr_class_t classify(input logic [MAC_W-1:0] dst,
                                             input logic [MAC_W-1:0] mac);
        addr_class_t c;
        logic grp;
        grp        = dst[MAC_W-8];
        c.bcast    = &dst;
        c.mcast    = grp && !c.bcast;
        c.uc_me    = !grp && (dst == mac);
        c.uc_other = !grp && (dst != mac);
        return c;
    endfunction

    function automatic logic [NUM_FILT-1:0] filter_hits(input addr_class_t c,
                                                        input frame_stat_t s);
        logic [NUM_FILT-1:0] h;
        h              = '0;
        h[F_CRC_COLL]  = s.crc_bad;
        h[F_RUNT_COLL] = s.runt;
        h[F_CRC_REJ]   = s.crc_bad;
        h[F_RUNT_REJ]  = s.runt;
        h[F_UC_ME]     = c.uc_me;
        h[F_UC_OTHER]  = c.uc_other;
        h[F_MCAST]     = c.mcast;
        h[F_BCAST]     = c.bcast;
        h[F_HASH]      = s.hash_hit;
        h[F_MAGIC]     = s.magic_hit;
        h[F_PATTERN]   = s.pattern_hit;
        return h;
    endfunction

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
    parameter int N_BYTES = 6,
    localparam int AW     = N_BYTES * 8,
    localparam int CW     = $clog2(N_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    output logic [AW-1:0] dst_addr
);
    localparam logic [CW-1:0] FULL = CW'(N_BYTES);

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (sof) begin
            addr_q <= '0;
            cnt_q  <= '0;
            if (byte_vld) begin
                addr_q[AW-1 -: 8] <= byte_in;
                cnt_q             <= CW'(1);
            end
        end else if (byte_vld && cnt_q < FULL) begin
            addr_q[8*(N_BYTES-1-int'(cnt_q)) +: 8] <= byte_in;
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign dst_addr = addr_q;

endmodule

// File: rtl/rxf_cfg_latch.sv
module rxf_cfg_latch #(
    parameter int              N   = 11,
    parameter logic [N-1:0]    DEF = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [N-1:0] cfg_wdata,
    input  logic         sof,
    output logic [N-1:0] frame_en
);
    logic [N-1:0] en_reg_q;
    logic [N-1:0] frame_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_reg_q   <= DEF;
            frame_en_q <= DEF;
        end else begin
            if (cfg_we) en_reg_q <= cfg_wdata;
            if (sof)    frame_en_q <= en_reg_q;
        end
    end

    assign frame_en = frame_en_q;

endmodule

// File: rtl/rxf_prio_resolve.sv
module rxf_prio_resolve #(
    parameter int           N       = 11,
    parameter logic [N-1:0] COLLECT = '1
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] hits,
    output logic         keep
);
    logic [N-1:0] live;

    for (genvar g = 0; g < N; g++) begin : g_live
        assign live[g] = en[g] & hits[g];
    end

    // Walk from lowest to highest priority; the last write is the winner.
    always_comb begin
        keep = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) keep = COLLECT[i];
        end
    end

endmodule

// File: rtl/eth_rx_filter_chain.sv
module eth_rx_filter_chain
    import rxf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             eof,
    input  logic             eof_crc_ok,
    input  logic [LEN_W-1:0] eof_len,
    input  logic [47:0]      local_mac,
    input  logic             cfg_we,
    input  logic [10:0]      cfg_wdata,
    input  logic             hash_hit,
    input  logic             magic_hit,
    input  logic             pattern_hit,
    output logic             verdict_valid,
    output logic             verdict_keep
);
    localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(MIN_FRAME);

    logic [MAC_W-1:0]    dst_addr;
    logic [NUM_FILT-1:0] cfg_frame;
    logic [NUM_FILT-1:0] hits;
    logic                keep_c;
    logic                frame_open;
    logic                close_ok;
    addr_class_t         cls;
    frame_stat_t         stat;

    rxf_addr_capture #(.N_BYTES(MAC_BYTES)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .sof      (sof),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .dst_addr (dst_addr)
    );

    rxf_cfg_latch #(.N(NUM_FILT), .DEF(EN_DEFAULT)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sof       (sof),
        .frame_en  (cfg_frame)
    );

    always_comb begin
        cls              = classify(dst_addr, local_mac);
        stat.crc_bad     = !eof_crc_ok;
        stat.runt        = eof_len < RUNT_LIM;
        stat.hash_hit    = hash_hit;
        stat.magic_hit   = magic_hit;
        stat.pattern_hit = pattern_hit;
        hits             = filter_hits(cls, stat);
    end

    rxf_prio_resolve #(.N(NUM_FILT), .COLLECT(COLLECT_MASK)) u_prio (
        .en   (cfg_frame),
        .hits (hits),
        .keep (keep_c)
    );

    assign close_ok = eof && frame_open && !sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_open    <= 1'b0;
            verdict_valid <= 1'b0;
            verdict_keep  <= 1'b0;
        end else begin
            if (sof)      frame_open <= 1'b1;
            else if (eof) frame_open <= 1'b0;
            verdict_valid <= close_ok;
            verdict_keep  <= close_ok & keep_c;
        end
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sof,
    input logic                eof,
    input logic                frame_open,
    input logic [NUM_FILT-1:0] cfg_frame,
    input logic                verdict_valid,
    input logic                verdict_keep
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);

    a_r7_follows_eof: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(eof));

    a_r8_cancel_on_sof: assert property (@(posedge clk) disable iff (rst)
        (eof && sof) |=> !verdict_valid);

    a_r8_orphan_eof: assert property (@(posedge clk) disable iff (rst)
        (eof && !frame_open) |=> !verdict_valid);

    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (frame_open && !sof) |=> $stable(cfg_frame));

    a_r2_none_enabled_drop: assert property (@(posedge clk) disable iff (rst)
        (eof && frame_open && !sof && cfg_frame == '0) |=> !verdict_keep);

endmodule

bind eth_rx_filter_chain rxf_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .sof           (sof),
    .eof           (eof),
    .frame_open    (frame_open),
    .cfg_frame     (cfg_frame),
    .verdict_valid (verdict_valid),
    .verdict_keep  (verdict_keep)
);

// File: tb/sim_eth_rx_filter_chain.sv
module sim_eth_rx_filter_chain;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] MY_MAC = 48'h02_1A_2B_3C_4D_5E;
    localparam logic [47:0] BCAST  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] OTHER  = 48'h00_11_22_33_44_55;
    localparam logic [47:0] MCAST  = 48'h01_00_5E_00_00_01;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst, sof, byte_vld, eof, eof_crc_ok, cfg_we;
    logic        hash_hit, magic_hit, pattern_hit;
    logic [7:0]  byte_in;
    logic [15:0] eof_len;
    logic [10:0] cfg_wdata;
    logic        verdict_valid, verdict_keep;

    int checks = 0;
    int fails  = 0;
    logic [10:0] en_shadow;

    eth_rx_filter_chain u0 (
        .clk(clk), .rst(rst), .sof(sof), .byte_vld(byte_vld), .byte_in(byte_in),
        .eof(eof), .eof_crc_ok(eof_crc_ok), .eof_len(eof_len),
        .local_mac(MY_MAC), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .hash_hit(hash_hit), .magic_hit(magic_hit), .pattern_hit(pattern_hit),
        .verdict_valid(verdict_valid), .verdict_keep(verdict_keep)
    );

    function automatic logic ref_keep(input logic [10:0] en, input logic [47:0] d,
                                      input logic crc_ok, input logic [15:0] len,
                                      input logic h, input logic m, input logic p);
        logic [10:0] hit;
        logic bc, mc, uc;
        bc = (d == BCAST);
        mc = d[40] && !bc;
        uc = !d[40];
        hit = {p, m, h, bc, mc, uc && d != MY_MAC, uc && d == MY_MAC,
               len < 16'd64, !crc_ok, len < 16'd64, !crc_ok};
        for (int i = 0; i < 11; i++)
            if (en[i] && hit[i]) return !(i == 2 || i == 3);
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [10:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; en_shadow = v;
    endtask

    task automatic send_frame(input string tag, input logic [47:0] dst, input int nbytes,
                              input logic crc_ok, input logic [15:0] len,
                              input logic h, input logic m, input logic p,
                              input logic mid_we, input logic [10:0] mid_val);
        logic [10:0] en_used;
        logic [47:0] d_eff;
        logic exp;
        d_eff = '0;
        en_used = en_shadow;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            sof = (i == 0);
            byte_vld = 1'b1;
            byte_in = (i < 6) ? dst[8*(5-i) +: 8] : 8'($urandom);
            if (i < 6) d_eff[8*(5-i) +: 8] = dst[8*(5-i) +: 8];
            cfg_we = mid_we && (i == 2);
            cfg_wdata = mid_val;
        end
        @(negedge clk);
        sof = 1'b0; byte_vld = 1'b0; cfg_we = 1'b0;
        if (mid_we) en_shadow = mid_val;
        eof = 1'b1; eof_crc_ok = crc_ok; eof_len = len;
        hash_hit = h; magic_hit = m; pattern_hit = p;
        @(negedge clk);
        eof = 1'b0; hash_hit = 1'b0; magic_hit = 1'b0; pattern_hit = 1'b0;
        exp = ref_keep(en_used, d_eff, crc_ok, len, h, m, p);
        chk(tag, "valid", 32'(verdict_valid), 32'd1);
        chk(tag, "keep", 32'(verdict_keep), 32'(exp));
        @(negedge clk);
        chk("R7", "pulse width", 32'(verdict_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] d;
        void'($urandom(32'd20240611));
        rst = 1'b1; sof = 0; byte_vld = 0; byte_in = 0; eof = 0; eof_crc_ok = 1;
        eof_len = 16'd100; cfg_we = 0; cfg_wdata = 0;
        hash_hit = 0; magic_hit = 0; pattern_hit = 0;
        en_shadow = 11'h09C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5", "reset valid", 32'(verdict_valid), 32'd0);

        // R5 default enable set; R3 classes; R4 runt boundary
        send_frame("R5", BCAST,  6, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R5", MY_MAC, 6, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R5", OTHER,  6, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R3", MCAST,  6, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R4", BCAST,  6, 0, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R4", MY_MAC, 6, 1, 16'd63,  0, 0, 0, 0, 0);
        send_frame("R4", MY_MAC, 6, 1, 16'd64,  0, 0, 0, 0, 0);

        // R2 nothing enabled / collect above reject / no hit
        cfg_write(11'h000);
        send_frame("R2", BCAST, 6, 1, 16'd100, 1, 1, 1, 0, 0);
        cfg_write(11'h005);
        send_frame("R2", OTHER, 6, 0, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R2", OTHER, 6, 1, 16'd100, 0, 0, 0, 0, 0);
        cfg_write(11'h00A);
        send_frame("R1", OTHER, 6, 1, 16'd30, 0, 0, 0, 0, 0);

        // R3 other-address and multicast classes
        cfg_write(11'h020);
        send_frame("R3", OTHER,  6, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R3", MY_MAC, 6, 1, 16'd100, 0, 0, 0, 0, 0);
        cfg_write(11'h040);
        send_frame("R3", MCAST, 6, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R3", BCAST, 6, 1, 16'd100, 0, 0, 0, 0, 0);

        // R10 external match flags
        cfg_write(11'h700);
        send_frame("R10", OTHER, 6, 1, 16'd100, 1, 0, 0, 0, 0);
        send_frame("R10", OTHER, 6, 1, 16'd100, 0, 1, 0, 0, 0);
        send_frame("R10", OTHER, 6, 1, 16'd100, 0, 0, 1, 0, 0);
        send_frame("R10", OTHER, 6, 1, 16'd100, 0, 0, 0, 0, 0);

        // R6 mid-frame write applies to next frame only
        cfg_write(11'h09C);
        send_frame("R6", BCAST, 6, 1, 16'd100, 0, 0, 0, 1, 11'h000);
        send_frame("R6", BCAST, 6, 1, 16'd100, 0, 0, 0, 0, 0);
        cfg_write(11'h09C);

        // R9 extra bytes ignored, missing bytes zero
        send_frame("R9", MY_MAC, 10, 1, 16'd100, 0, 0, 0, 0, 0);
        send_frame("R9", BCAST,  2,  1, 16'd100, 0, 0, 0, 0, 0);

        // R8 same-cycle sof/eof cancels; orphan eof ignored
        @(negedge clk); sof = 1; byte_vld = 1; byte_in = 8'hFF;
        @(negedge clk); sof = 0; byte_vld = 0;
        @(negedge clk); sof = 1; eof = 1;
        @(negedge clk); sof = 0; eof = 0;
        chk("R8", "cancel valid", 32'(verdict_valid), 32'd0);
        for (int i = 0; i < 6; i++) begin
            byte_vld = 1; byte_in = 8'hFF;
            @(negedge clk);
        end
        byte_vld = 0; eof = 1; eof_crc_ok = 1; eof_len = 16'd80;
        @(negedge clk); eof = 0;
        chk("R8", "restarted frame valid", 32'(verdict_valid), 32'd1);
        chk("R8", "restarted frame keep", 32'(verdict_keep), 32'd1);
        @(negedge clk); eof = 1;
        @(negedge clk); eof = 0;
        chk("R8", "orphan eof", 32'(verdict_valid), 32'd0);

        // Random frames against the reference model (R1 R2)
        for (int n = 0; n < 400; n++) begin
            int pick;
            if (n % 25 == 0) cfg_write(11'($urandom));
            pick = $urandom_range(0, 4);
            case (pick)
                0: d = BCAST;
                1: d = MY_MAC;
                2: d = {$urandom, 16'($urandom)} | 48'h0100_0000_0000;
                default: d = {$urandom, 16'($urandom)} & ~48'h0100_0000_0000;
            endcase
            send_frame("R2", d, $urandom_range(6, 9), 1'($urandom_range(0, 3) != 0),
                       16'($urandom_range(40, 120)), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom_range(0, 9) == 0), 11'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule